// File: doc/BRIEF.md
# Ordered Key Loader with Checksum

This block keeps one region's 128-bit cipher key. Software writes the key as four 32-bit words through a plain write port. The block watches the order in which the words arrive. Only when word 0, word 1, word 2 and word 3 land in that order, each exactly once, does it publish an 8-bit CRC of the key and raise a key-valid flag. Software reads the CRC back to confirm the key without ever reading the key itself: the key readback port always returns zero.

Two set-once lock bits guard the key. The key lock freezes the key and its CRC. The config lock also freezes the region's 2-bit mode field, and setting it forces the key lock on. Only reset clears either lock. When the mode field changes while the key is unlocked, the stored key and its CRC are wiped, so a key loaded for one mode cannot be reused under another.

Top module: `key_seq_loader`

## Requirements
- R1: A write to word index i (0 to 3) stores the data in key bits [32*i+31 : 32*i] of `key_o`, visible on the cycle after the write.
- R2: The CRC uses polynomial 0x07 (x^8+x^2+x+1), an initial value of 0x00 and no final XOR. The 16 key bytes are fed in order from bits [7:0] of word 0 up to bits [31:24] of word 3, and each byte is fed most significant bit first.
- R3: When word 3 completes the ordered sequence 0,1,2,3, `crc_o` shows the CRC of those four words and `key_valid_o` is 1, both from the cycle after that write.
- R4: `crc_o` is 0 whenever `key_valid_o` is 0. A write to word 0 always starts a new sequence: it clears the published CRC and the valid flag, even after a completed sequence.
- R5: A write to a word other than the one expected, or a repeated write after completion, clears the CRC and the valid flag. Both stay 0 until a fresh sequence that starts at word 0 completes.
- R6: `key_rdata` is always zero, whatever has been written.
- R7: A key word write is discarded, with no effect on the key, the CRC or the sequence, while the key lock or the config lock is set.
- R8: Each lock bit is set by a config write and stays set until reset. Setting the config lock also sets the key lock.
- R9: While the key lock is set, `key_o`, `crc_o` and `key_valid_o` hold their values, including across a change of mode.
- R10: A config write that changes the mode while the key lock is clear zeroes the key, the CRC and the valid flag on the next cycle. A config write that leaves the mode unchanged wipes nothing.
- R11: While the config lock is set, config writes are discarded: the mode and the lock bits keep their values.
- R12: After reset the key, CRC, valid flag, mode and both lock bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 2 | Index of the key word being written (0 to 3) |
| key_wdata | input | 32 | Key word data |
| key_rdata | output | 32 | Key word readback, always zero |
| cfg_we | input | 1 | Config write strobe |
| cfg_mode | input | 2 | Mode value carried by a config write |
| cfg_klock_set | input | 1 | Sets the key lock when written as 1 |
| cfg_clock_set | input | 1 | Sets the config lock (and the key lock) when written as 1 |
| key_o | output | 128 | Stored key |
| crc_o | output | 8 | Published key CRC, zero unless valid |
| key_valid_o | output | 1 | A complete ordered sequence has been loaded |
| mode_o | output | 2 | Current mode field |
| key_lock_o | output | 1 | Key lock state |
| cfg_lock_o | output | 1 | Config lock state |

## Verification
The sequence tracker is driven with a clean ordered load, a restart at word 0 after completion, a skipped index, a repeated index partway through, a repeat of word 3 after completion and an all-zero key. These separate a tracker that checks order from one that only counts writes, and a published CRC from a running one. Each write is followed by a comparison of the CRC against a bitwise reference over the written words, so byte order and bit order errors show up with non-trivial data. Mode changes are tried with the same value and with a new value, each with the lock clear and with it set, which separates a true change from a plain write and a wipe from a locked hold.

// File: rtl/kl_pkg.sv
package kl_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_WORDS = 4;
    localparam int unsigned CRC_W     = 8;
    localparam int unsigned MODE_W    = 2;
    localparam int unsigned KEY_W     = WORD_W * NUM_WORDS;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
    localparam int unsigned BYTES_W   = WORD_W / 8;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam widx_t LAST_IDX = widx_t'(NUM_WORDS - 1);

    typedef struct packed {
        logic  en;
        widx_t idx;
        word_t data;
    } key_wr_t;

    typedef struct packed {
        logic  en;
        mode_t mode;
        logic  klock_set;
        logic  clock_set;
    } cfg_wr_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_BROKEN = 2'd2
    } seq_st_e;

    // Advance the CRC over one word: low byte first, each byte MSB first.
    function automatic crc_t crc_step_word(crc_t c_in, word_t w);
        crc_t c;
        logic fb;
        c = c_in;
        for (int b = 0; b < int'(BYTES_W); b++) begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[CRC_W-1] ^ w[8*b + i];
                c  = {c[CRC_W-2:0], 1'b0};
                if (fb) c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/kl_key_store.sv
module kl_key_store
    import kl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  key_wr_t          wr,
    output logic [KEY_W-1:0] key_o
);

    word_t words [NUM_WORDS];

    for (genvar g = 0; g < int'(NUM_WORDS); g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || wipe) begin
                words[g] <= '0;
            end else if (wr.en && wr.idx == widx_t'(g)) begin
                words[g] <= wr.data;
            end
        end
        assign key_o[g*WORD_W +: WORD_W] = words[g];
    end

endmodule

// File: rtl/kl_seq_tracker.sv
module kl_seq_tracker
    import kl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wipe,
    input  key_wr_t wr,
    output crc_t    crc_o,
    output logic    valid_o
);

    seq_st_e st;
    widx_t   nxt;
    crc_t    acc;
    crc_t    acc_next;

    always_comb begin
        acc_next = crc_step_word((wr.idx == '0) ? '0 : acc, wr.data);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            st      <= SEQ_IDLE;
            nxt     <= '0;
            acc     <= '0;
            crc_o   <= '0;
            valid_o <= 1'b0;
        end else if (wr.en) begin
            if (wr.idx == '0) begin
                st      <= SEQ_RUN;
                nxt     <= widx_t'(1);
                acc     <= acc_next;
                crc_o   <= '0;
                valid_o <= 1'b0;
            end else if (st == SEQ_RUN && wr.idx == nxt) begin
                acc <= acc_next;
                if (wr.idx == LAST_IDX) begin
                    st      <= SEQ_IDLE;
                    nxt     <= '0;
                    crc_o   <= acc_next;
                    valid_o <= 1'b1;
                end else begin
                    nxt <= nxt + widx_t'(1);
                end
            end else begin
                st      <= SEQ_BROKEN;
                nxt     <= '0;
                crc_o   <= '0;
                valid_o <= 1'b0;
            end
        end
    end

    AST_VALID_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(wr.en && wr.idx == LAST_IDX && !wipe)) else $error("AST_VALID_NEEDS_LAST"); // R3

    AST_CRC_ZERO_INVALID: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> crc_o == '0) else $error("AST_CRC_ZERO_INVALID"); // R4

    AST_FIRST_WORD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == '0) |=> !valid_o) else $error("AST_FIRST_WORD_CLEARS"); // R4

endmodule

// File: rtl/kl_lock_ctrl.sv
module kl_lock_ctrl
    import kl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t cfg,
    output mode_t   mode_o,
    output logic    key_lock_o,
    output logic    cfg_lock_o,
    output logic    wipe_o
);

    logic accept;

    assign accept = cfg.en && !cfg_lock_o;
    assign wipe_o = accept && !key_lock_o && (cfg.mode != mode_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o     <= '0;
            key_lock_o <= 1'b0;
            cfg_lock_o <= 1'b0;
        end else if (accept) begin
            mode_o     <= cfg.mode;
            key_lock_o <= key_lock_o | cfg.klock_set | cfg.clock_set;
            cfg_lock_o <= cfg.clock_set;
        end
    end

    AST_KEY_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        key_lock_o |=> key_lock_o) else $error("AST_KEY_LOCK_STICKY"); // R8

    AST_CFG_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_lock_o |=> (cfg_lock_o && key_lock_o)) else $error("AST_CFG_LOCK_STICKY"); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        cfg_lock_o |=> $stable(mode_o)) else $error("AST_MODE_HELD"); // R11

endmodule

// File: rtl/key_seq_loader.sv
module key_seq_loader
    import kl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [IDX_W-1:0]  key_idx,
    input  logic [WORD_W-1:0] key_wdata,
    output logic [WORD_W-1:0] key_rdata,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_klock_set,
    input  logic              cfg_clock_set,
    output logic [KEY_W-1:0]  key_o,
    output logic [CRC_W-1:0]  crc_o,
    output logic              key_valid_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              key_lock_o,
    output logic              cfg_lock_o
);

    key_wr_t kwr;
    cfg_wr_t cwr;
    logic    wipe;

    assign key_rdata = '0;

    assign cwr.en        = cfg_we;
    assign cwr.mode      = cfg_mode;
    assign cwr.klock_set = cfg_klock_set;
    assign cwr.clock_set = cfg_clock_set;

    assign kwr.en   = key_we && !key_lock_o && !cfg_lock_o;
    assign kwr.idx  = key_idx;
    assign kwr.data = key_wdata;

    kl_lock_ctrl u_lock (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cwr),
        .mode_o     (mode_o),
        .key_lock_o (key_lock_o),
        .cfg_lock_o (cfg_lock_o),
        .wipe_o     (wipe)
    );

    kl_key_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wipe  (wipe),
        .wr    (kwr),
        .key_o (key_o)
    );

    kl_seq_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .wr      (kwr),
        .crc_o   (crc_o),
        .valid_o (key_valid_o)
    );

    AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        key_lock_o |=> $stable(key_o)) else $error("AST_KEY_FROZEN"); // R9

    AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        key_lock_o |=> ($stable(crc_o) && $stable(key_valid_o))) else $error("AST_CRC_FROZEN"); // R9

    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (key_we && (key_lock_o || cfg_lock_o)) |=> $stable(key_o)) else $error("AST_LOCKED_WRITE_DROPPED"); // R7

    AST_MODE_WIPE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_lock_o && !key_lock_o && cfg_mode != mode_o)
        |=> (key_o == '0 && crc_o == '0 && !key_valid_o)) else $error("AST_MODE_WIPE"); // R10

endmodule

// File: tb/sim_key_seq_loader.sv
module sim_key_seq_loader;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_we = 1'b0;
    logic [1:0]   key_idx = '0;
    logic [31:0]  key_wdata = '0;
    logic [31:0]  key_rdata;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_mode = '0;
    logic         cfg_klock_set = 1'b0;
    logic         cfg_clock_set = 1'b0;
    logic [127:0] key_o;
    logic [7:0]   crc_o;
    logic         key_valid_o;
    logic [1:0]   mode_o;
    logic         key_lock_o;
    logic         cfg_lock_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_seq_loader u0 (
        .clk(clk), .rst(rst), .key_we(key_we), .key_idx(key_idx),
        .key_wdata(key_wdata), .key_rdata(key_rdata), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_klock_set(cfg_klock_set),
        .cfg_clock_set(cfg_clock_set), .key_o(key_o), .crc_o(crc_o),
        .key_valid_o(key_valid_o), .mode_o(mode_o),
        .key_lock_o(key_lock_o), .cfg_lock_o(cfg_lock_o)
    );

    // {expected valid, word index, data}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 32'h0123_4567},
        {1'b0, 2'd1, 32'h89AB_CDEF},
        {1'b0, 2'd2, 32'hDEAD_BEEF},
        {1'b1, 2'd3, 32'h0F1E_2D3C},
        {1'b0, 2'd0, 32'hA5A5_5A5A},
        {1'b0, 2'd2, 32'h1111_2222},
        {1'b0, 2'd1, 32'h3333_4444},
        {1'b0, 2'd2, 32'h5555_6666},
        {1'b0, 2'd3, 32'h7777_8888},
        {1'b0, 2'd0, 32'hCAFE_F00D},
        {1'b0, 2'd1, 32'h0BAD_F00D},
        {1'b0, 2'd1, 32'h1234_0000},
        {1'b0, 2'd2, 32'hFFFF_0000},
        {1'b0, 2'd3, 32'h0000_FFFF},
        {1'b0, 2'd0, 32'h8000_0001},
        {1'b0, 2'd1, 32'h4000_0002},
        {1'b0, 2'd2, 32'h2000_0004},
        {1'b1, 2'd3, 32'h1000_0008},
        {1'b0, 2'd3, 32'h1000_0008},
        {1'b0, 2'd0, 32'h0000_0000},
        {1'b0, 2'd1, 32'h0000_0000},
        {1'b0, 2'd2, 32'h0000_0000},
        {1'b1, 2'd3, 32'h0000_0000},
        {1'b0, 2'd0, 32'hFFFF_FFFF},
        {1'b0, 2'd1, 32'h0102_0304},
        {1'b0, 2'd2, 32'hF0E0_D0C0},
        {1'b1, 2'd3, 32'h7F00_00FE}
    };

    logic [31:0] model [4];

    // Reference CRC: poly 0x07, init 0, no final XOR, byte 0 (key[7:0]) first, MSB first.
    function automatic logic [7:0] ref_crc(logic [127:0] k);
        logic [7:0] r = 8'h00;
        for (int n = 0; n < 16; n++) begin
            for (int i = 7; i >= 0; i--) begin
                if (r[7] ^ k[8*n + i]) r = (r << 1) ^ 8'h07;
                else                   r = r << 1;
            end
        end
        return r;
    endfunction

    function automatic logic [127:0] model_key();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic key_write(logic [1:0] idx, logic [31:0] d);
        @(negedge clk);
        key_we = 1'b1; key_idx = idx; key_wdata = d;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic cfg_write(logic [1:0] m, logic kl, logic cl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_klock_set = kl; cfg_clock_set = cl;
        @(negedge clk);
        cfg_we = 1'b0; cfg_klock_set = 1'b0; cfg_clock_set = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [127:0] held_key;
        logic [7:0]   held_crc;

        do_reset();
        chk("R12 key",   key_o, '0);
        chk("R12 crc",   128'(crc_o), '0);
        chk("R12 valid", 128'(key_valid_o), '0);
        chk("R12 mode",  128'(mode_o), '0);
        chk("R12 klock", 128'(key_lock_o), '0);
        chk("R12 clock", 128'(cfg_lock_o), '0);

        for (int i = 0; i < 4; i++) model[i] = '0;

        // Sequence table: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            logic        ev;
            logic [1:0]  ix;
            logic [31:0] dt;
            {ev, ix, dt} = VEC[v];
            model[ix] = dt;
            key_write(ix, dt);
            chk(ev ? "R2 R3 crc" : "R4 R5 crc", 128'(crc_o), ev ? 128'(ref_crc(model_key())) : '0);
            chk(ev ? "R3 valid" : "R4 R5 valid", 128'(key_valid_o), 128'(ev));
            chk("R1 key", key_o, model_key());
        end

        chk("R1 mapping", key_o, {32'h7F00_00FE, 32'hF0E0_D0C0, 32'h0102_0304, 32'hFFFF_FFFF});
        chk("R6 readback", 128'(key_rdata), '0);

        // R10: mode change wipes
        cfg_write(2'b01, 1'b0, 1'b0);
        chk("R10 wipe key",   key_o, '0);
        chk("R10 wipe crc",   128'(crc_o), '0);
        chk("R10 wipe valid", 128'(key_valid_o), '0);
        chk("R10 mode",       128'(mode_o), 128'(2'b01));

        model[0] = 32'h1357_9BDF; model[1] = 32'h2468_ACE0;
        model[2] = 32'hFEDC_BA98; model[3] = 32'h7654_3210;
        for (int i = 0; i < 4; i++) key_write(2'(i), model[i]);
        chk("R3 reload valid", 128'(key_valid_o), 128'(1));
        held_key = key_o;
        held_crc = crc_o;
        chk("R2 reload crc", 128'(held_crc), 128'(ref_crc(model_key())));

        cfg_write(2'b01, 1'b0, 1'b0);
        chk("R10 same mode keeps crc", 128'(crc_o), 128'(held_crc));
        chk("R10 same mode keeps key", key_o, held_key);

        // R7 R9: key lock
        cfg_write(2'b01, 1'b1, 1'b0);
        chk("R8 klock set", 128'(key_lock_o), 128'(1));
        key_write(2'd0, 32'hAAAA_AAAA);
        chk("R7 locked write key", key_o, held_key);
        chk("R7 locked write crc", 128'(crc_o), 128'(held_crc));
        chk("R7 locked write valid", 128'(key_valid_o), 128'(1));
        cfg_write(2'b10, 1'b0, 1'b0);
        chk("R9 mode moved", 128'(mode_o), 128'(2'b10));
        chk("R9 key held", key_o, held_key);
        chk("R9 crc held", 128'(crc_o), 128'(held_crc));

        // R8 R11: config lock
        cfg_write(2'b10, 1'b0, 1'b1);
        chk("R8 clock set", 128'(cfg_lock_o), 128'(1));
        cfg_write(2'b11, 1'b0, 1'b0);
        chk("R11 mode held", 128'(mode_o), 128'(2'b10));
        chk("R8 clock sticky", 128'(cfg_lock_o), 128'(1));
        chk("R8 klock sticky", 128'(key_lock_o), 128'(1));

        do_reset();
        chk("R8 reset clears klock", 128'(key_lock_o), '0);
        chk("R8 reset clears clock", 128'(cfg_lock_o), '0);
        cfg_write(2'b00, 1'b0, 1'b1);
        chk("R8 clock forces klock", 128'(key_lock_o), 128'(1));
        key_write(2'd0, 32'h5555_AAAA);
        chk("R7 cfg-locked write", key_o, '0);
        chk("R6 readback locked", 128'(key_rdata), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule